// File: doc/BRIEF.md
# Control Word Block-Command Target

This block sits behind a serial management bus target that has already matched its address. It receives each transaction as a stream of bytes plus one-cycle start, stop and read-request strobes. It decodes block-command frames that read or write a packed array of 4-bit control words. Two control words share each byte of a byte-addressed register space. Writes carry one, two or four data bytes. Reads always return a full aligned 32-bit block inside a fixed six-byte response: a count, a status, then four data bytes.

One control word is the command-space word. Writing all ones to it does nothing. Any other value is latched and announced on a strobe. One code, `RESET_CODE`, returns every control word to its reset value. A host reads in three steps: it sends a read frame and a stop, it re-sends the lone command byte, and after a repeated start it clocks out the response bytes one per read request.

Top module: `cwt_target`

## Requirements
- R1: A frame counts only if command bit 7 (first packet) and bit 6 (last packet) are both 1 and bits 1:0 equal 2'b10 (block transfer). Any other frame is discarded with no register update.
- R2: Command bits 3:2 select the operation: 00 read, 01 byte write, 10 word write, 11 double-word write. The count byte must be 4, 5, 6 or 8 respectively. On a mismatch the frame is discarded, and the next response reports status 0x10 with zero data.
- R3: A byte write to register low byte A stores the data byte at byte A modulo the space size. This updates both 4-bit words in that byte: word i lives in byte i/2, low nibble for even i.
- R4: A word write to A stores the first data byte at A+1 and the second at A, with addresses wrapping inside the space.
- R5: A double-word write masks the low two address bits to give base B. It stores its four data bytes at B+3, B+2, B+1 and B, in order of arrival.
- R6: A start resets the response pointer. Each read request then steps through these bytes: 0x05, the status, data bytes at B+3, B+2, B+1 and B, then 0xFF for any further request.
- R7: A read ignores the two lowest address bits and returns the aligned 32-bit block.
- R8: The status byte is 0x01 after an accepted read frame. It is 0x10 before any frame and after a discarded frame, and in both of those cases the data bytes are zero.
- R9: A frame cut short by a stop or start is discarded with no register update.
- R10: When command bit 4 is set, one trailing error-code byte is accepted and takes no part in the data.
- R11: Writing 4'hF to the command-space word leaves that word unchanged and raises no strobe. Its byte neighbour is still written.
- R12: Any other value written to the command-space word is latched there and pulses `cmd_strobe` with `cmd_code`. If the value is `RESET_CODE`, the whole write is dropped and all words return to their reset values.
- R13: A frame made of a single command byte, as used before a repeated-start read, changes neither the registers nor the response status.
- R14: After reset, every control word is 0 except the command-space word, which is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe for a start or repeated start |
| bus_stop | input | 1 | One-cycle strobe for a stop |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Host consumed the current response byte |
| tx_byte | output | 8 | Response byte currently presented |
| ctrl_words | output | 4*NUM_WORDS | All control words; word i at bits 4i+3:4i |
| cmd_strobe | output | 1 | One-cycle pulse when a command is latched |
| cmd_code | output | 4 | Last latched command code |

## Verification
Several properties are checked on every cycle. The count byte follows every start. Only 0x01 or 0x10 appears in the status slot. The command-space word changes only together with a strobe and never takes 4'hF from a write. A reset command leaves exactly the reset pattern. The control words stay stable unless a frame closed two cycles earlier. What the assertions cannot show is frame acceptance and data placement. These are covered by the bench scenarios: byte ordering for each write size, address masking and wrap, the error-code byte, short or mis-counted frames, and the lone command byte.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    OP_RD = 2'b00,
    OP_WB = 2'b01,
    OP_WW = 2'b10,
    OP_WD = 2'b11
  } op_e;

  localparam logic [7:0] RSP_COUNT = 8'h05;
  localparam logic [7:0] STS_OK    = 8'h01;
  localparam logic [7:0] STS_ABORT = 8'h10;
  localparam logic [7:0] RSP_PAD   = 8'hFF;

  typedef struct packed {
    logic        ok;
    op_e         op;
    logic [7:0]  addr;
    logic [31:0] data;
  } frame_t;

  function automatic logic [7:0] count_for(op_e op);
    case (op)
      OP_RD:   count_for = 8'd4;
      OP_WB:   count_for = 8'd5;
      OP_WW:   count_for = 8'd6;
      default: count_for = 8'd8;
    endcase
  endfunction

  function automatic logic [2:0] lanes_for(op_e op);
    case (op)
      OP_RD:   lanes_for = 3'd0;
      OP_WB:   lanes_for = 3'd1;
      OP_WW:   lanes_for = 3'd2;
      default: lanes_for = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cwt_frame_rx.sv
module cwt_frame_rx
  import cwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ev_valid,
  output frame_t     ev
);

  // command bits kept: [6]=first, [5]=last, [4]=pec, [3:2]=op, [1:0]=bus type
  logic [6:0]  cmd_q, cmd_d;
  logic [7:0]  len_q, len_d;
  logic [7:0]  addr_q, addr_d;
  logic [31:0] data_q, data_d;
  logic [3:0]  cnt_q, cnt_d;
  logic        evv_q, evv_d;
  frame_t      ev_q, ev_d;

  logic        closing;
  logic [8:0]  want_len;
  logic [8:0]  payload_end;
  op_e         cur_op;

  assign cur_op      = op_e'(cmd_q[3:2]);
  assign payload_end = {1'b0, len_q} + 9'd2;
  assign want_len    = payload_end + {8'd0, cmd_q[4]};
  assign closing     = (bus_start | bus_stop) && (cnt_q != 4'd0);

  always_comb begin
    cmd_d  = cmd_q;
    len_d  = len_q;
    addr_d = addr_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    evv_d  = 1'b0;
    ev_d   = ev_q;
    if (closing) begin
      cnt_d      = 4'd0;
      evv_d      = (cnt_q != 4'd1);
      ev_d.op    = cur_op;
      ev_d.addr  = addr_q;
      ev_d.data  = data_q;
      ev_d.ok    = cmd_q[6] && cmd_q[5] && (cmd_q[1:0] == 2'b10) &&
                   (len_q == count_for(cur_op)) &&
                   (want_len == {5'd0, cnt_q});
    end else if (bus_start) begin
      cnt_d = 4'd0;
    end else if (rx_valid) begin
      cnt_d = (cnt_q == 4'd15) ? cnt_q : cnt_q + 4'd1;
      case (cnt_q)
        4'd0: begin
          cmd_d  = {rx_byte[7:6], rx_byte[4:0]};
          data_d = 32'd0;
        end
        4'd1:    len_d  = rx_byte;
        4'd5:    addr_d = rx_byte;
        default: begin
          if (cnt_q >= 4'd6 && {5'd0, cnt_q} < payload_end)
            data_d = {data_q[23:0], rx_byte};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      evv_q  <= 1'b0;
      ev_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      len_q  <= len_d;
      addr_q <= addr_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      evv_q  <= evv_d;
      ev_q   <= ev_d;
    end
  end

  assign ev_valid = evv_q;
  assign ev       = ev_q;

endmodule

// File: rtl/cwt_regfile.sv
module cwt_regfile
  import cwt_pkg::*;
#(
  parameter int         NUM_WORDS  = 32,
  parameter int         CMD_IDX    = 6,
  parameter logic [3:0] RESET_CODE = 4'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  input  frame_t                 ev,
  output logic [4*NUM_WORDS-1:0] mem_flat,
  output logic                   cmd_strobe,
  output logic [3:0]             cmd_code
);

  localparam int NB       = NUM_WORDS / 2;
  localparam int AW       = $clog2(NB);
  localparam int W        = 4 * NUM_WORDS;
  localparam int CMD_BYTE = CMD_IDX / 2;
  localparam int CMD_POS  = 4 * CMD_IDX;
  localparam logic [W-1:0] RST_FLAT = {{(W-4){1'b0}}, 4'hF} << CMD_POS;

  logic [W-1:0]  mem_q, mem_d, wr_flat;
  logic          stb_q, stb_d;
  logic [3:0]    code_q, code_d;
  logic          do_wr;
  logic [7:0]    addr8;
  logic [AW-1:0] base;
  logic [2:0]    lanes;
  logic [NB-1:0] hit_v;
  logic [3:0]    new_nib;
  logic          cmd_hit;

  assign do_wr = ev_valid && ev.ok && (ev.op != OP_RD);
  assign addr8 = (ev.op == OP_WD) ? {ev.addr[7:2], 2'b00} : ev.addr;
  assign base  = AW'(addr8 % 8'(NB));
  assign lanes = lanes_for(ev.op);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [AW-1:0] off;
    assign off      = AW'(b) - base;
    assign hit_v[b] = do_wr && (32'(off) < 32'(lanes));
    assign wr_flat[8*b +: 8] = hit_v[b] ? ev.data[8*off[1:0] +: 8]
                                        : mem_q[8*b +: 8];
  end

  assign new_nib = wr_flat[CMD_POS +: 4];
  assign cmd_hit = hit_v[CMD_BYTE] && (new_nib != 4'hF);

  always_comb begin
    mem_d  = wr_flat;
    stb_d  = cmd_hit;
    code_d = cmd_hit ? new_nib : code_q;
    if (new_nib == 4'hF)
      mem_d[CMD_POS +: 4] = mem_q[CMD_POS +: 4];
    if (cmd_hit && new_nib == RESET_CODE)
      mem_d = RST_FLAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= RST_FLAT;
      stb_q  <= 1'b0;
      code_q <= 4'hF;
    end else begin
      if (do_wr) mem_q <= mem_d;
      stb_q  <= stb_d;
      code_q <= code_d;
    end
  end

  assign mem_flat   = mem_q;
  assign cmd_strobe = stb_q;
  assign cmd_code   = code_q;

endmodule

// File: rtl/cwt_rsp_tx.sv
module cwt_rsp_tx
  import cwt_pkg::*;
#(
  parameter int NUM_WORDS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_start,
  input  logic                   rd_req,
  input  logic                   ev_valid,
  input  logic                   ev_ok,
  input  op_e                    ev_op,
  input  logic [7:0]             ev_addr,
  input  logic [4*NUM_WORDS-1:0] mem_flat,
  output logic [7:0]             tx_byte
);

  localparam int NB = NUM_WORDS / 2;
  localparam int AW = $clog2(NB);

  logic [2:0]    ptr_q, ptr_d;
  logic          ok_q, ok_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] idx;
  logic [7:0]    addr_al;

  assign addr_al = {ev_addr[7:2], 2'b00};

  always_comb begin
    ptr_d  = ptr_q;
    ok_d   = ok_q;
    base_d = base_q;
    if (bus_start)
      ptr_d = 3'd0;
    else if (rd_req && ptr_q != 3'd6)
      ptr_d = ptr_q + 3'd1;
    if (ev_valid) begin
      if (!ev_ok) begin
        ok_d = 1'b0;
      end else if (ev_op == OP_RD) begin
        ok_d   = 1'b1;
        base_d = AW'(addr_al % 8'(NB));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ok_q   <= 1'b0;
      base_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      ok_q   <= ok_d;
      base_q <= base_d;
    end
  end

  assign idx = base_q + AW'(3'd5 - ptr_q);

  always_comb begin
    case (ptr_q)
      3'd0:                      tx_byte = RSP_COUNT;
      3'd1:                      tx_byte = ok_q ? STS_OK : STS_ABORT;
      3'd2, 3'd3, 3'd4, 3'd5:    tx_byte = ok_q ? mem_flat[8*idx +: 8] : 8'h00;
      default:                   tx_byte = RSP_PAD;
    endcase
  end

endmodule

// File: rtl/cwt_target.sv
module cwt_target
  import cwt_pkg::*;
#(
  parameter int         NUM_WORDS  = 32,
  parameter int         CMD_IDX    = 6,
  parameter logic [3:0] RESET_CODE = 4'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_start,
  input  logic                   bus_stop,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  input  logic                   rd_req,
  output logic [7:0]             tx_byte,
  output logic [4*NUM_WORDS-1:0] ctrl_words,
  output logic                   cmd_strobe,
  output logic [3:0]             cmd_code
);

  logic   ev_valid;
  frame_t ev;

  cwt_frame_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .ev_valid (ev_valid),
    .ev       (ev)
  );

  cwt_regfile #(
    .NUM_WORDS (NUM_WORDS),
    .CMD_IDX   (CMD_IDX),
    .RESET_CODE(RESET_CODE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev        (ev),
    .mem_flat  (ctrl_words),
    .cmd_strobe(cmd_strobe),
    .cmd_code  (cmd_code)
  );

  cwt_rsp_tx #(
    .NUM_WORDS(NUM_WORDS)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .rd_req   (rd_req),
    .ev_valid (ev_valid),
    .ev_ok    (ev.ok),
    .ev_op    (ev.op),
    .ev_addr  (ev.addr),
    .mem_flat (ctrl_words),
    .tx_byte  (tx_byte)
  );

endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int         NUM_WORDS  = 32,
  parameter int         CMD_IDX    = 6,
  parameter logic [3:0] RESET_CODE = 4'h0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_start,
  input logic                   bus_stop,
  input logic                   rd_req,
  input logic [7:0]             tx_byte,
  input logic [4*NUM_WORDS-1:0] ctrl_words,
  input logic                   cmd_strobe,
  input logic [3:0]             cmd_code
);

  localparam int W = 4 * NUM_WORDS;
  localparam logic [W-1:0] RST_PATTERN = {{(W-4){1'b0}}, 4'hF} << (4 * CMD_IDX);

  logic [3:0] cmd_word;
  assign cmd_word = ctrl_words[4*CMD_IDX +: 4];

  assert_count_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !rd_req) |=> (tx_byte == 8'h05));

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_start) && rd_req && !bus_start) |=> (tx_byte == 8'h01 || tx_byte == 8'h10));

  assert_nop_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> (cmd_code != 4'hF));

  assert_cmd_word_moves_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_word) |-> cmd_strobe);

  assert_cmd_latched_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code != RESET_CODE) |-> (cmd_word == cmd_code));

  assert_reset_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == RESET_CODE) |-> (ctrl_words == RST_PATTERN));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_stop, 2) || $past(bus_start, 2)) |-> $stable(ctrl_words));

endmodule

bind cwt_target cwt_checker #(
  .NUM_WORDS (NUM_WORDS),
  .CMD_IDX   (CMD_IDX),
  .RESET_CODE(RESET_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .rd_req    (rd_req),
  .tx_byte   (tx_byte),
  .ctrl_words(ctrl_words),
  .cmd_strobe(cmd_strobe),
  .cmd_code  (cmd_code)
);

// File: tb/cwt_target_tb_top.sv
`timescale 1ns/1ps
module cwt_target_tb_top;

  localparam int NW = 32;
  localparam int VW = 83;
  localparam int NV = 7;

  // {op[1:0], addr[7:0], data[31:0], pec, read_addr[7:0], expected[31:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b11, 8'h08, 32'h11223344, 1'b0, 8'h08, 32'h11223344},  // R5 aligned dword
    {2'b11, 8'h05, 32'hA1B2C3D4, 1'b0, 8'h04, 32'hA1B2C3D4},  // R5 unaligned masked
    {2'b01, 8'h09, 32'h0000005A, 1'b0, 8'h0B, 32'h11225A44},  // R3 byte, R7 unaligned read
    {2'b10, 8'h0C, 32'h0000BEEF, 1'b0, 8'h0C, 32'h0000BEEF},  // R4 word
    {2'b10, 8'h0F, 32'h00001234, 1'b0, 8'h0C, 32'h3400BEEF},  // R4 wrap
    {2'b11, 8'h00, 32'h7F665544, 1'b1, 8'h00, 32'h7F665544},  // R10 pec, R11 nop nibble
    {2'b01, 8'h03, 32'h00000025, 1'b0, 8'h00, 32'h25665544}   // R12 command 5
  };

  logic          clk = 1'b0;
  logic          rst_n, bus_start, bus_stop, rx_valid, rd_req;
  logic [7:0]    rx_byte, tx_byte;
  logic [4*NW-1:0] ctrl_words;
  logic          cmd_strobe;
  logic [3:0]    cmd_code;

  int n_checks = 0;
  int n_fail   = 0;
  int n_strobe = 0;
  logic [3:0] last_code = 4'hF;
  logic [7:0] rsp [7];

  always #2 clk = ~clk;

  cwt_target #(.NUM_WORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req), .tx_byte(tx_byte),
    .ctrl_words(ctrl_words), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
  );

  always @(negedge clk) if (rst_n && cmd_strobe) begin
    n_strobe++;
    last_code = cmd_code;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] cmd, input logic [7:0] cnt, input logic [7:0] addr,
                            input logic [31:0] data, input int ndata, input bit pec);
    pulse_start();
    send_byte(cmd); send_byte(cnt); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h00); send_byte(addr);
    for (int i = ndata - 1; i >= 0; i--) send_byte(data[8*i +: 8]);
    if (pec) send_byte(8'hA5);
    pulse_stop();
    idle(3);
  endtask

  task automatic read_rsp();
    pulse_start();
    for (int i = 0; i < 7; i++) begin
      rsp[i] = tx_byte;
      rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
    end
    pulse_stop();
    idle(2);
  endtask

  task automatic do_read(input logic [7:0] addr);
    send_frame(8'hC2, 8'd4, addr, 32'd0, 0, 1'b0);
    pulse_start();
    send_byte(8'hC2);
    read_rsp();
  endtask

  function automatic logic [31:0] rsp_data();
    return {rsp[2], rsp[3], rsp[4], rsp[5]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    rx_valid = 1'b0; rx_byte = 8'h00; rd_req = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R14 reset pattern, R8 status before any frame, R6 padding
    check(ctrl_words == 128'h0F00_0000, "R14 reset words", ctrl_words, 128'h0F00_0000);
    read_rsp();
    check(rsp[0] == 8'h05, "R6 count byte", rsp[0], 8'h05);
    check(rsp[1] == 8'h10 && rsp_data() == 32'd0, "R8 status before frame",
          {rsp[1], rsp_data()}, {8'h10, 32'd0});
    check(rsp[6] == 8'hFF, "R6 padding byte", rsp[6], 8'hFF);

    // table walk: write then read back
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [7:0]  ad, ra;
      logic [31:0] dt, ex;
      logic        pe;
      int          nd;
      {op, ad, dt, pe, ra, ex} = VEC[v];
      nd = (op == 2'b01) ? 1 : (op == 2'b10) ? 2 : 4;
      send_frame(8'hC2 | {4'b0, op, 2'b00} | (pe ? 8'h10 : 8'h00),
                 8'd4 + 8'(nd), ad, dt, nd, pe);
      do_read(ra);
      check(rsp[1] == 8'h01 && rsp_data() == ex, $sformatf("R3 R4 R5 R7 vector %0d", v),
            {rsp[1], rsp_data()}, {8'h01, ex});
    end

    // R12 one strobe for the non-ones command, none for the ones value (R11)
    check(n_strobe == 1 && last_code == 4'h5, "R12 R11 strobe count/code",
          {n_strobe[7:0], last_code}, {8'd1, 4'h5});

    // R2 count mismatch: discarded, status 0x10
    send_frame(8'hC6, 8'd6, 8'h09, 32'h99, 1, 1'b0);
    check(ctrl_words[79:72] == 8'h5A, "R2 mismatched count no write", ctrl_words[79:72], 8'h5A);
    read_rsp();
    check(rsp[1] == 8'h10 && rsp_data() == 32'd0, "R2 R8 status after discard",
          {rsp[1], rsp_data()}, {8'h10, 32'd0});

    // R9 early stop
    send_frame(8'hCE, 8'd8, 8'h08, 32'hDEAD, 2, 1'b0);
    check(ctrl_words[95:64] == 32'h11225A44, "R9 short frame no write",
          ctrl_words[95:64], 32'h11225A44);

    // R1 missing first-packet flag
    send_frame(8'h46, 8'd5, 8'h09, 32'h77, 1, 1'b0);
    check(ctrl_words[79:72] == 8'h5A, "R1 bad flags no write", ctrl_words[79:72], 8'h5A);
    // R1 byte transfer type rejected
    send_frame(8'hC4, 8'd5, 8'h09, 32'h77, 1, 1'b0);
    check(ctrl_words[79:72] == 8'h5A, "R1 bus type no write", ctrl_words[79:72], 8'h5A);

    // R12 reset command
    send_frame(8'hC6, 8'd5, 8'h03, 32'h30, 1, 1'b0);
    check(ctrl_words == 128'h0F00_0000, "R12 reset command words", ctrl_words, 128'h0F00_0000);
    check(n_strobe == 2 && last_code == 4'h0, "R12 reset strobe",
          {n_strobe[7:0], last_code}, {8'd2, 4'h0});
    do_read(8'h02);
    check(rsp[1] == 8'h01 && rsp_data() == 32'h0F00_0000, "R7 R8 read after reset",
          {rsp[1], rsp_data()}, {8'h01, 32'h0F00_0000});

    // R13 lone command byte keeps status and words
    pulse_start();
    send_byte(8'hC6);
    pulse_stop();
    idle(3);
    read_rsp();
    check(rsp[1] == 8'h01 && rsp_data() == 32'h0F00_0000, "R13 lone command byte",
          {rsp[1], rsp_data()}, {8'h01, 32'h0F00_0000});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule